// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block chooses the sampling-clock tap for a high-speed SD/eMMC receive path once a tuning sweep has finished. The sweep probes every one of N delay taps twice, in two passes. The caller hands over the results as a 2N-bit pass map, together with N and a one-cycle start request. The block first merges the two passes, so that a tap position counts as good only if both of its probes passed. It then walks the merged map one entry per clock and finds the longest run of consecutive good entries. If that run is long enough, the centre of the run, folded back into the range 0..N-1, becomes the new tap.

When the block finishes it pulses `done`. On success it updates `tap_sel` and raises `retune_en`, which asks the surrounding logic to enable automatic re-tuning. On failure it pulses `fail` in the same cycle and leaves `tap_sel` unchanged. When a selection is accepted, the block pulses `clear_req` for one cycle and drops `retune_en`, so that any pending re-tuning request or error status outside the block is cleared before the new search begins.

Top module: `tap_window_sel`

## Requirements
- R1: Entry i of the merged map is good only when pass_map bit i and its twin are both 1. The twin is bit i+N for i<N and bit i-N for N<=i<2N.
- R2: The search covers all 2N merged entries and finds the longest run of consecutive good entries. This includes a run that ends on entry 2N-1.
- R3: A later run replaces the best run only when it is strictly longer, so on a tie the run with the lowest start wins.
- R4: When the longest run is shorter than 3 entries, `fail` is 1 in the `done` cycle, `tap_sel` keeps its previous value and `retune_en` stays 0.
- R5: On success, `tap_sel` = ((run_start + run_end) / 2) mod N, with integer division, where run_start and run_end are the first and last entries of the chosen run.
- R6: On success, `retune_en` goes to 1 in the `done` cycle and holds until the next accepted start.
- R7: In the cycle after an accepted start, `clear_req` is 1 for exactly one cycle and `retune_en` is 0.
- R8: `done` is a single-cycle pulse. It is seen 2N+1 clock edges after the edge that accepts `start`. `fail` is 1 only in a `done` cycle.
- R9: pass_map bits at or above position 2N have no effect on the result.
- R10: `start` is ignored while a selection is in progress, including in the cycle that produces `done`. It neither restarts the search nor changes the result.
- R11: After synchronous active-high reset, the block is idle, `tap_sel` is 0, and `done`, `fail`, `retune_en` and `clear_req` are 0.
- R12: `tap_count` is sampled when start is accepted. A value of 0 is treated as 1, and a value above 16 is treated as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a selection; accepted only when idle |
| tap_count | input | 5 | Number of taps N (1..16) |
| pass_map | input | 32 | Sweep results: bits 0..N-1 hold the first pass, bits N..2N-1 the second |
| tap_sel | output | 4 | Selected sampling tap |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No run of at least 3 good entries; valid with done |
| retune_en | output | 1 | Request to enable automatic re-tuning after a successful selection |
| clear_req | output | 1 | One-cycle pulse that clears pending re-tuning and error status |

## Verification
Two events can fall in the same cycle. The first is closing the trailing run on the last scan entry while the result is produced. The second is a new start request arriving in that same final cycle. The bench drives a start both in the middle of a scan and exactly on the edge that produces `done`. It judges the outcome by checking that the result matches the first request and that no `clear_req` pulse follows. Tie cases are also chosen so that the trailing run equals the best run in length, which shows that the earlier run is kept when both are closed together.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_FINAL = 2'd2
  } tws_state_e;
endpackage

// File: rtl/tws_merge.sv
// Folds the two sweep passes into one map: an entry is good only if its twin
// in the other pass also passed. Entries at or above 2N are forced to zero.
module tws_merge #(
  parameter int MAX_TAPS = 16,
  parameter int VEC_W    = 2 * MAX_TAPS,
  parameter int CNT_W    = $clog2(MAX_TAPS + 1),
  parameter int IDX_W    = $clog2(VEC_W)
) (
  input  logic [VEC_W-1:0] raw,
  input  logic [CNT_W-1:0] n,
  output logic [VEC_W-1:0] merged
);
  for (genvar gi = 0; gi < VEC_W; gi++) begin : g_bit
    logic [IDX_W-1:0] up_i;
    logic [IDX_W-1:0] dn_i;
    assign up_i = IDX_W'(gi) + IDX_W'(n);
    assign dn_i = IDX_W'(gi) - IDX_W'(n);
    always_comb begin
      if (gi < int'(n))
        merged[gi] = raw[gi] & raw[up_i];
      else if (gi < 2 * int'(n))
        merged[gi] = raw[gi] & raw[dn_i];
      else
        merged[gi] = 1'b0;
    end
  end
endmodule

// File: rtl/tws_scan.sv
// Longest-run tracker: one entry per step; strict compare keeps earliest run.
module tws_scan #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             bit_in,
  input  logic [LEN_W-1:0] pos,
  input  logic [LEN_W-1:0] total,
  output logic [LEN_W-1:0] fin_len,
  output logic [LEN_W-1:0] fin_start
);
  logic [LEN_W-1:0] cur_len;
  logic [LEN_W-1:0] best_len;
  logic [LEN_W-1:0] best_start;

  always_ff @(posedge clk) begin
    if (rst || load) begin
      cur_len    <= '0;
      best_len   <= '0;
      best_start <= '0;
    end else if (step) begin
      if (bit_in) begin
        cur_len <= cur_len + 1'b1;
      end else begin
        if (cur_len > best_len) begin
          best_len   <= cur_len;
          best_start <= pos - cur_len;
        end
        cur_len <= '0;
      end
    end
  end

  // trailing run that reaches the last entry is closed here
  always_comb begin
    if (cur_len > best_len) begin
      fin_len   = cur_len;
      fin_start = total - cur_len;
    end else begin
      fin_len   = best_len;
      fin_start = best_start;
    end
  end

  // R2
  best_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> best_len >= $past(best_len));
endmodule

// File: rtl/tws_pick.sv
// Midpoint of the winning run, folded back into 0..N-1, plus run-length gate.
module tws_pick #(
  parameter int LEN_W   = 6,
  parameter int CNT_W   = 5,
  parameter int TAP_W   = 4,
  parameter int MIN_RUN = 3
) (
  input  logic [LEN_W-1:0] run_len,
  input  logic [LEN_W-1:0] run_start,
  input  logic [CNT_W-1:0] n,
  output logic [TAP_W-1:0] tap,
  output logic             ok
);
  localparam int SUM_W = LEN_W + 2;
  logic [SUM_W-1:0] twice_mid;
  logic [SUM_W-1:0] mid;
  logic [SUM_W-1:0] folded;

  assign ok        = run_len >= LEN_W'(MIN_RUN);
  // start + end = 2*start + len - 1
  assign twice_mid = {1'b0, run_start, 1'b0} + SUM_W'(run_len) - SUM_W'(1);
  assign mid       = twice_mid >> 1;
  assign folded    = (n == '0) ? '0 : (mid % SUM_W'(n));
  assign tap       = TAP_W'(folded);
endmodule

// File: rtl/tap_window_sel.sv
module tap_window_sel #(
  parameter int MAX_TAPS = 16,
  parameter int MIN_RUN  = 3,
  parameter int VEC_W    = 2 * MAX_TAPS,
  parameter int CNT_W    = $clog2(MAX_TAPS + 1),
  parameter int TAP_W    = $clog2(MAX_TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] tap_count,
  input  logic [VEC_W-1:0] pass_map,
  output logic [TAP_W-1:0] tap_sel,
  output logic             done,
  output logic             fail,
  output logic             retune_en,
  output logic             clear_req
);
  import tws_pkg::*;

  localparam int IDX_W = $clog2(VEC_W);
  localparam int LEN_W = $clog2(VEC_W + 1);

  tws_state_e       state;
  logic [CNT_W-1:0] n_eff;
  logic [CNT_W-1:0] n_lat;
  logic [VEC_W-1:0] merged_w;
  logic [VEC_W-1:0] merged_q;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] total;
  logic [LEN_W-1:0] fin_len;
  logic [LEN_W-1:0] fin_start;
  logic [TAP_W-1:0] pick_tap;
  logic             pick_ok;
  logic             accept;
  logic             scanning;

  // clamp requested tap count into 1..MAX_TAPS
  always_comb begin
    if (tap_count == '0)
      n_eff = CNT_W'(1);
    else if (tap_count > CNT_W'(MAX_TAPS))
      n_eff = CNT_W'(MAX_TAPS);
    else
      n_eff = tap_count;
  end

  assign accept   = start && (state == ST_IDLE);
  assign scanning = (state == ST_SCAN);
  assign total    = {n_lat, 1'b0};

  tws_merge #(
    .MAX_TAPS(MAX_TAPS), .VEC_W(VEC_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) merge_i (
    .raw(pass_map), .n(n_eff), .merged(merged_w)
  );

  tws_scan #(.LEN_W(LEN_W)) scan_i (
    .clk(clk), .rst(rst), .load(accept), .step(scanning),
    .bit_in(merged_q[idx[IDX_W-1:0]]), .pos(idx), .total(total),
    .fin_len(fin_len), .fin_start(fin_start)
  );

  tws_pick #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .TAP_W(TAP_W), .MIN_RUN(MIN_RUN)
  ) pick_i (
    .run_len(fin_len), .run_start(fin_start), .n(n_lat),
    .tap(pick_tap), .ok(pick_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx       <= '0;
      merged_q  <= '0;
      n_lat     <= CNT_W'(1);
      tap_sel   <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      retune_en <= 1'b0;
      clear_req <= 1'b0;
    end else begin
      done      <= 1'b0;
      fail      <= 1'b0;
      clear_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            merged_q  <= merged_w;
            n_lat     <= n_eff;
            idx       <= '0;
            retune_en <= 1'b0;
            clear_req <= 1'b1;
            state     <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          idx <= idx + 1'b1;
          if (idx == total - 1'b1) state <= ST_FINAL;
        end
        ST_FINAL: begin
          done <= 1'b1;
          if (pick_ok) begin
            tap_sel   <= pick_tap;
            retune_en <= 1'b1;
          end else begin
            fail <= 1'b1;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8
  fail_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);
  // R4
  fail_keeps_tap_chk: assert property (@(posedge clk) disable iff (rst)
    (done && fail) |-> $stable(tap_sel));
  // R6
  retune_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(retune_en) |-> (done && !fail));
  // R5
  tap_range_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fail) |-> (CNT_W'(tap_sel) < n_lat));
  // R7
  clear_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (clear_req && !retune_en));
  // R10
  busy_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start && state != ST_IDLE) |=> !clear_req);
endmodule

// File: tb/tap_window_sel_tb_top.sv
`timescale 1ns/1ps
module tap_window_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  tap_count = 5'd1;
  logic [31:0] pass_map = '0;
  logic [3:0]  tap_sel;
  logic        done, fail, retune_en, clear_req;

  int total_cnt = 0;
  int bad_cnt   = 0;
  int exp_tap   = 0;
  int cycles    = 0;

  always #2.5 clk = ~clk;

  tap_window_sel dut_i (
    .clk(clk), .rst(rst), .start(start), .tap_count(tap_count),
    .pass_map(pass_map), .tap_sel(tap_sel), .done(done), .fail(fail),
    .retune_en(retune_en), .clear_req(clear_req)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp_n(input int n);
    if (n == 0) return 1;      // R12
    if (n > 16) return 16;
    return n;
  endfunction

  // reference selection, built from the requirements
  function automatic void ref_pick(input logic [31:0] map, input int n_raw,
                                   output bit ok, output int tap);
    int n = clamp_n(n_raw);
    bit m[32];
    int cur = 0, best = 0, bstart = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < n)          m[i] = map[i] & map[i + n];   // R1
      else if (i < 2 * n) m[i] = map[i] & map[i - n];
      else                m[i] = 1'b0;                  // R9
    end
    for (int i = 0; i < 2 * n; i++) begin
      if (m[i]) cur++;
      else begin
        if (cur > best) begin best = cur; bstart = i - cur; end  // R3
        cur = 0;
      end
    end
    if (cur > best) begin best = cur; bstart = 2 * n - cur; end  // R2
    ok  = (best >= 3);
    tap = ok ? ((bstart + bstart + best - 1) / 2) % n : 0;       // R5
  endfunction

  // inject: 0 none, 1 start mid-scan, 2 start on the final edge
  task automatic do_run(input logic [31:0] map, input int n, input int inject,
                        input string tag);
    bit eok; int etap; int nc; int k; int lat;
    nc = clamp_n(n);
    ref_pick(map, n, eok, etap);
    if (eok) exp_tap = etap;
    @(negedge clk);
    start = 1'b1; pass_map = map; tap_count = 5'(n);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(clear_req == 1'b1, "R7", {tag, " clear_req"}, clear_req, 1);
    chk(retune_en == 1'b0, "R7", {tag, " retune cleared"}, retune_en, 0);
    k = 0; lat = -1;
    while (lat < 0 && k < 100) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (done) lat = k;
      if (lat < 0 && inject == 1 && k == 1) begin
        start = 1'b1; pass_map = ~map;          // R10 mid-scan
      end else if (lat < 0 && inject == 2 && k == 2 * nc) begin
        start = 1'b1; pass_map = ~map;          // R10 on final edge
      end else start = 1'b0;
    end
    start = 1'b0;
    chk(lat == 2 * nc + 1, "R8", {tag, " latency"}, lat, 2 * nc + 1);
    chk(fail == !eok, "R4", {tag, " fail"}, fail, !eok);
    chk(int'(tap_sel) == exp_tap, eok ? "R5" : "R4", {tag, " tap"},
        tap_sel, exp_tap);
    chk(retune_en == eok, "R6", {tag, " retune_en"}, retune_en, eok);
    @(posedge clk); @(negedge clk);
    chk(done == 1'b0, "R8", {tag, " done pulse width"}, done, 0);
    chk(clear_req == 1'b0, "R10", {tag, " no restart"}, clear_req, 0);
    chk(retune_en == eok, "R6", {tag, " retune held"}, retune_en, eok);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad_cnt++; total_cnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11
    chk(tap_sel == 0 && done == 0 && fail == 0, "R11", "reset outputs",
        {tap_sel, done, fail}, 0);
    chk(retune_en == 0 && clear_req == 0, "R11", "reset flags",
        {retune_en, clear_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && tap_sel == 0, "R11", "idle after reset", done, 0);

    do_run(32'hFFFF_FFFF, 16, 0, "R2 all pass trailing run");       // tap 15
    do_run(32'h0000_0000, 16, 0, "R4 none pass");
    do_run(32'h0000_7777, 8, 0, "R3 equal runs");                   // tap 1
    do_run(32'h0000_03DE, 5, 0, "R3 trailing tie");                 // tap 2
    do_run(32'h0000_0033, 4, 0, "R4 run of two");
    do_run(32'hFFFF_FF77, 4, 0, "R9 upper bits set");               // tap 1
    do_run(32'h0000_000F, 4, 0, "R1 second pass fails");
    do_run(32'h0000_FEFF, 8, 0, "R1 one twin fails");               // tap 4
    do_run(32'h0000_0003, 0, 0, "R12 zero count");
    do_run(32'hFFFF_FFFF, 20, 0, "R12 large count");                // tap 15
    do_run(32'h0000_FFFF, 8, 1, "R10 start mid-scan");
    do_run(32'h0000_00FF, 4, 2, "R10 start on final edge");
    do_run(32'hFFFF_FFFF, 1, 0, "R5 single tap");                   // fail, 2 entries

    for (int t = 0; t < 40; t++) begin
      logic [31:0] mp;
      int n;
      mp = $urandom() | $urandom();
      n  = 1 + ($urandom() % 16);
      do_run(mp, n, int'($urandom() % 3), "R5 random");
    end

    $display("test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end
endmodule